// File: doc/BRIEF.md
# One-Line Comb Luma/Chroma Separator

This block splits a sampled composite video stream into luminance and chrominance by comparing each sample with the sample at the same position one line earlier. Samples arrive one per clock at three times the colour subcarrier rate. A line-start strobe marks the first sample of every line. On a neighbouring line the subcarrier phase is inverted, so half the difference between the two lines keeps the colour carrier and cancels the vertically correlated picture content. A short fixed band-pass FIR then keeps only the carrier band of that difference.

Luminance is not filtered on its own path. The stored one-line-delayed composite is delayed further so that it lines up with the chroma pipeline, and the chroma is then subtracted from it. Both outputs therefore leave on the same clock edge. A bypass select replaces both outputs with external luma and chroma inputs. A valid flag tells the downstream logic when the line memory holds a complete line of real data.

Top module: `vcomb_separator`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it rises, y_out and c_out are 0 and out_valid is 0.
- R2: For sample n, the stored sample p(n) is the previous one at the same line-memory address, and the line difference is d(n) = floor((p(n) - x(n)) / 2), formed with one guard bit.
- R3: c_out for sample n is clip((2*d(n) - d(n-1) - d(n+1)) >>> BPF_SHIFT), an arithmetic shift.
- R4: y_out for sample n is clip(p(n) - c(n)), where c(n) is the chroma value of R3.
- R5: clip() saturates to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1] and never wraps.
- R6: A sample presented at clock edge t reaches both y_out and c_out after edge t+4. Both paths have the same latency.
- R7: If bypass is sampled high at edge b, then from edge b+1 each edge loads y_out from y_ext and c_out from c_ext, as sampled on that same edge.
- R8: y_out and c_out change between comb and external source on the same edge, so no output word mixes the two modes.
- R9: out_valid stays low for at least LINE_LEN edges after reset release or after bypass is sampled low again. In comb mode it is high no later than LINE_LEN+8 edges after that point.
- R10: out_valid is high on every edge on which the outputs carry the external inputs (R7).
- R11: A sample with line_start high uses line-memory address 0. Every other sample uses the previous address plus one, wrapping from LINE_LEN-1 to 0. Short and long lines therefore compare against whatever was last written at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, three times the subcarrier rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | High on the first sample of each line |
| bypass | input | 1 | Selects the external luma/chroma inputs |
| cvbs_in | input | DW | Signed composite sample |
| y_ext | input | DW | Signed external luma sample |
| c_ext | input | DW | Signed external chroma sample |
| y_out | output | DW | Signed luminance output |
| c_out | output | DW | Signed chrominance output |
| out_valid | output | 1 | Output data is meaningful |

## Verification
The bench drives the comb with several kinds of composite input, each of which tells apart a different part of the arithmetic:
- A flat level should give zero chroma and unchanged luma.
- A subcarrier that inverts from line to line should be passed fully into chroma.
- A subcarrier that does not invert should cancel.
- A luminance step between lines should land in the difference path and then be shaped by the band-pass.
- Pseudo-random content exercises all taps together.
- A large inverted carrier drives the chroma sum into saturation.

Short and long lines check that the line-start strobe restarts the address and that the comparison falls back on stale entries. Bypass segments, including one that lasts only a single line, check the switch-over edge and the behaviour of the valid flag.

// File: rtl/vcomb_pkg.sv
// Shared definitions for the one-line comb separator.
// Assumes: a single clock domain; all sample words are signed two's complement.
package vcomb_pkg;

    // Output source selection
    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_EXT  = 1'b1
    } path_sel_e;

    // Band-pass FIR length on the line difference
    localparam int FIR_TAPS = 3;
    // Edges from line-store output to the chroma register (difference + taps + sum)
    localparam int FIR_LAT  = 3;
    // Output selection register
    localparam int OUT_LAT  = 1;
    // Total edges from line-store output to the block outputs
    localparam int PIPE_LAT = FIR_LAT + OUT_LAT;

endpackage

// File: rtl/vcomb_line_store.sv
// One-line circular sample memory.
// Every clock writes the incoming sample at the current address. In the same
// cycle it returns the word that was previously stored there, i.e. the sample
// at the same position one line earlier (R2). The address restarts at zero on
// line_start and otherwise advances, wrapping after DEPTH-1 (R11).
// Assumes: one sample per clock; the memory content is not reset.
module vcomb_line_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 683
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] cur_q,
    output logic signed [DW-1:0] dly_q
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] addr;

    // Address for this sample: restart on a line start, otherwise continue
    assign addr = line_start ? '0 : wp_q;

    // Store the new sample over the one-line-old entry
    always_ff @(posedge clk) begin
        mem[addr] <= din;
    end

    // Advance the pointer; present the current and the one-line-old sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            cur_q <= '0;
            dly_q <= '0;
        end else begin
            wp_q  <= (addr == LAST) ? '0 : addr + 1'b1;
            cur_q <= din;
            dly_q <= $signed(mem[addr]);
        end
    end

endmodule

// File: rtl/vcomb_chroma_bpf.sv
// Line-difference chroma extractor.
// Halves the difference (old line - new line) using one guard bit (R2). It then
// applies the fixed band-pass kernel [-1, 2, -1], scaled by 2^-SHIFT, centred
// on the middle sample (R3), and saturates the result to DW bits (R5).
// Latency: FIR_LAT edges from the line-store outputs to c_q.
// Assumes: cur and dly are aligned samples of the same line position.
module vcomb_chroma_bpf
    import vcomb_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SHIFT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] cur,
    input  logic signed [DW-1:0] dly,
    output logic signed [DW-1:0] c_q
);
    localparam int SW = DW + 3;
    localparam logic signed [SW-1:0] HI = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] LO = ~HI;

    // Saturate a wide sum to the DW-bit signed range
    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > HI)      return HI[DW-1:0];
        else if (v < LO) return LO[DW-1:0];
        else             return v[DW-1:0];
    endfunction

    logic signed [DW:0]   gap;
    logic signed [DW-1:0] diff_q;
    logic signed [DW-1:0] tap_q [FIR_TAPS-1];
    logic signed [SW-1:0] e_new, e_cen, e_old, acc, scaled;

    // Guard-bit difference; dropping the LSB halves it with floor rounding
    assign gap = $signed({dly[DW-1], dly}) - $signed({cur[DW-1], cur});

    // Register the halved difference and shift it along the tap line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            for (int i = 0; i < FIR_TAPS - 1; i++) tap_q[i] <= '0;
        end else begin
            diff_q   <= gap[DW:1];
            tap_q[0] <= diff_q;
            for (int i = 1; i < FIR_TAPS - 1; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    assign e_new  = SW'(diff_q);
    assign e_cen  = SW'(tap_q[0]);
    assign e_old  = SW'(tap_q[FIR_TAPS-2]);
    assign acc    = (e_cen <<< 1) - e_new - e_old;
    assign scaled = acc >>> SHIFT;

    // Register the saturated band-passed chroma
    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= clip(scaled);
    end

endmodule

// File: rtl/vcomb_align.sv
// Fixed register delay that matches the composite path to the chroma latency.
// STAGES = 0 gives a plain wire.
// Assumes: a delay of a few edges only.
module vcomb_align #(
    parameter int W      = 8,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] sr [STAGES];
            // Shift the word one stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
                end
            end
            assign q = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/vcomb_separator.sv
// One-line comb luma/chroma separator (top).
// Chroma is the band-passed half line difference. Luma is the delay-matched,
// one-line-old composite minus that chroma (R4), so both leave on the same
// edge (R6). A registered bypass select switches both outputs together to the
// external inputs (R7, R8). out_valid waits for a full line after reset or
// after bypass ends (R9), and is high while bypassed (R10).
// Assumes: one composite sample per clock; line_start marks line starts.
module vcomb_separator
    import vcomb_pkg::*;
#(
    parameter int DW        = 8,
    parameter int LINE_LEN  = 683,
    parameter int BPF_SHIFT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic                 bypass,
    input  logic signed [DW-1:0] cvbs_in,
    input  logic signed [DW-1:0] y_ext,
    input  logic signed [DW-1:0] c_ext,
    output logic signed [DW-1:0] y_out,
    output logic signed [DW-1:0] c_out,
    output logic                 out_valid
);
    localparam int FILL_MAX = LINE_LEN + PIPE_LAT;
    localparam int FW       = $clog2(FILL_MAX + 1);
    localparam logic [FW-1:0] FILL_TOP = FW'(FILL_MAX);
    localparam logic signed [DW:0] YHI = (DW+1)'((1 << (DW - 1)) - 1);
    localparam logic signed [DW:0] YLO = ~YHI;

    // Saturate a guard-bit difference back to DW bits
    function automatic logic signed [DW-1:0] clip_y(input logic signed [DW:0] v);
        if (v > YHI)      return YHI[DW-1:0];
        else if (v < YLO) return YLO[DW-1:0];
        else              return v[DW-1:0];
    endfunction

    logic signed [DW-1:0] cur_s, dly_s, chroma, comp;
    logic [DW-1:0]        comp_bits;
    logic signed [DW:0]   y_full;
    path_sel_e            path_q;
    logic [FW-1:0]        fill_q;

    vcomb_line_store #(.DW(DW), .DEPTH(LINE_LEN)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .din        (cvbs_in),
        .cur_q      (cur_s),
        .dly_q      (dly_s)
    );

    vcomb_chroma_bpf #(.DW(DW), .SHIFT(BPF_SHIFT)) u_bpf (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur_s),
        .dly   (dly_s),
        .c_q   (chroma)
    );

    vcomb_align #(.W(DW), .STAGES(FIR_LAT)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dly_s),
        .q     (comp_bits)
    );

    assign comp   = $signed(comp_bits);
    assign y_full = $signed({comp[DW-1], comp}) - $signed({chroma[DW-1], chroma});

    // Register the mode select once so that both outputs see the same value
    always_ff @(posedge clk) begin
        if (!rst_n) path_q <= PATH_COMB;
        else        path_q <= bypass ? PATH_EXT : PATH_COMB;
    end

    // Count comb-mode edges until a full line plus the pipeline is filled
    always_ff @(posedge clk) begin
        if (!rst_n || path_q == PATH_EXT) fill_q <= '0;
        else if (fill_q != FILL_TOP)      fill_q <= fill_q + 1'b1;
    end

    // Output selection and validity, loaded on one common edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out     <= '0;
            c_out     <= '0;
            out_valid <= 1'b0;
        end else if (path_q == PATH_EXT) begin
            y_out     <= y_ext;
            c_out     <= c_ext;
            out_valid <= 1'b1;
        end else begin
            y_out     <= clip_y(y_full);
            c_out     <= chroma;
            out_valid <= (fill_q == FILL_TOP);
        end
    end

endmodule

// File: rtl/vcomb_separator_chk.sv
// Port-level protocol checks for vcomb_separator, attached by bind.
// Assumes: the checked instance uses the same DW and LINE_LEN.
module vcomb_separator_chk #(
    parameter int DW       = 8,
    parameter int LINE_LEN = 683
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bypass,
    input logic signed [DW-1:0] y_ext,
    input logic signed [DW-1:0] c_ext,
    input logic signed [DW-1:0] y_out,
    input logic signed [DW-1:0] c_out,
    input logic                 out_valid
);
    localparam int CW = $clog2(LINE_LEN + 1);
    localparam logic [CW-1:0] CTOP = CW'(LINE_LEN);

    logic [CW-1:0] quiet_q;

    // Edges since reset release or since bypass was last sampled high
    always_ff @(posedge clk) begin
        if (!rst_n || bypass)   quiet_q <= '0;
        else if (quiet_q != CTOP) quiet_q <= quiet_q + 1'b1;
    end

    // R1: first edge after reset shows a cleared output
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (y_out == '0 && c_out == '0 && !out_valid));

    // R7, R8: both outputs carry the external words on the same edge
    p_ext_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(bypass, 2))
        |-> (y_out == $past(y_ext) && c_out == $past(c_ext)));

    // R10: valid while bypassed
    p_ext_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(bypass, 2)) |-> out_valid);

    // R9: leaving bypass drops valid
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $past(bypass) && $past(rst_n)) |-> ##2 !out_valid);

    // R9: in comb mode valid needs at least one line of quiet edges
    p_valid_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(bypass) && !$past(bypass, 2)) |-> (quiet_q >= CTOP));

endmodule

bind vcomb_separator vcomb_separator_chk #(.DW(DW), .LINE_LEN(LINE_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass    (bypass),
    .y_ext     (y_ext),
    .c_ext     (c_ext),
    .y_out     (y_out),
    .c_out     (c_out),
    .out_valid (out_valid)
);

// File: tb/tb_vcomb_separator.sv
`timescale 1ns/1ps
// Bench for vcomb_separator. A vector table of line patterns is walked by one
// loop; expected outputs come from a model built on the requirements.
// Tags exercised: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11.
module tb_vcomb_separator;
    localparam int DW   = 8;
    localparam int L    = 12;
    localparam int SH   = 1;
    localparam int HMAX = 4096;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n, line_start, bypass;
    logic signed [DW-1:0] cvbs_in, y_ext, c_ext, y_out, c_out;
    logic                 out_valid;

    vcomb_separator #(.DW(DW), .LINE_LEN(L), .BPF_SHIFT(SH)) dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .bypass(bypass),
        .cvbs_in(cvbs_in), .y_ext(y_ext), .c_ext(c_ext),
        .y_out(y_out), .c_out(c_out), .out_valid(out_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n     = 0;
    int kstart = 0;
    int pos   = 0;
    int cur_tag = 1;
    int xh [HMAX];
    int ph [HMAX];
    bit kh [HMAX];
    bit bh [HMAX];
    int yeh[HMAX];
    int ceh[HMAX];
    int mm [L];
    bit mk [L];

    // kinds: 0 flat, 1 inverting carrier, 2 non-inverting carrier,
    //        3 line-alternating level, 4 pseudo-random
    localparam int NV = 13;
    localparam int V_KIND [NV] = '{0, 1, 2, 3, 4, 1, 4, 4, 4, 4, 4, 4, 0};
    localparam int V_AMP  [NV] = '{40, 30, 30, 50, 100, 60, 90, 100, 80, 80, 70, 60, -50};
    localparam int V_LINES[NV] = '{3, 4, 3, 4, 4, 3, 3, 4, 2, 3, 2, 1, 3};
    localparam int V_LEN  [NV] = '{L, L, L, L, L, L, L, L, 7, L, 15, L, L};
    localparam int V_BYP  [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0};
    // requirement stressed by each entry: R2 R3 R3 R4 R6 R5 R7 R9 R11 R11 R11 R8 R2
    localparam int V_TAG  [NV] = '{2, 3, 3, 4, 6, 5, 7, 9, 11, 11, 11, 8, 2};

    function automatic int clip(input int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int gen(input int kind, input int a, input int ln, input int p, input int idx);
        int base;
        base = (p % 3 == 0) ? 2 * a : -a;
        case (kind)
            1:       return (ln % 2 != 0) ? -base : base;
            2:       return base;
            3:       return (ln % 2 != 0) ? -a : a;
            4:       return ((idx * 37 + ln * 11 + p * 5) % (2 * a + 1)) - a;
            default: return a;
        endcase
    endfunction

    function automatic int dif(input int j);
        return (ph[j] - xh[j]) >>> 1;
    endfunction

    task automatic fail_line(input string what, input int act, input int exp);
        n_bad++;
        $display("FAIL %s (entry R%0d) sample %0d: actual %0d expected %0d", what, cur_tag, n, act, exp);
    endtask

    // Check the outputs loaded on the previous edge
    task automatic check_out();
        int e, m, ce, ye;
        if (n < 2) return;
        e = n - 1;
        if (bh[n-2]) begin
            // R7 R8 R10: both outputs from the external inputs, valid high
            n_chk++;
            if (y_out != yeh[e]) fail_line("R7 luma bypass", y_out, yeh[e]);
            n_chk++;
            if (c_out != ceh[e]) fail_line("R8 chroma bypass", c_out, ceh[e]);
            n_chk++;
            if (out_valid !== 1'b1) fail_line("R10 valid in bypass", out_valid, 1);
        end else begin
            if (e < kstart + L) begin
                n_chk++;
                if (out_valid !== 1'b0) fail_line("R9 early valid", out_valid, 0);
            end
            if (e >= kstart + L + 8) begin
                n_chk++;
                if (out_valid !== 1'b1) fail_line("R9 late valid", out_valid, 1);
            end
            m = n - 5;
            if (m >= 1 && kh[m-1] && kh[m] && kh[m+1]) begin
                // R2 R3 R5 R6: chroma; R4: luma
                ce = clip((2 * dif(m) - dif(m-1) - dif(m+1)) >>> SH);
                ye = clip(ph[m] - ce);
                n_chk++;
                if (c_out != ce) fail_line("R3 chroma", c_out, ce);
                n_chk++;
                if (y_out != ye) fail_line("R4 luma", y_out, ye);
            end
        end
    endtask

    // Drive one sample and update the address model of R11
    task automatic drive(input int x, input bit ls, input bit byp);
        int addr, ye, ce;
        ye = ((n * 7) % 200) - 100;
        ce = ((n * 13) % 180) - 90;
        line_start = ls;
        bypass     = byp;
        cvbs_in    = DW'(x);
        y_ext      = DW'(ye);
        c_ext      = DW'(ce);
        addr   = ls ? 0 : pos;
        xh[n]  = x;
        ph[n]  = mm[addr];
        kh[n]  = mk[addr];
        mm[addr] = x;
        mk[addr] = 1'b1;
        pos    = (addr == L - 1) ? 0 : addr + 1;
        bh[n]  = byp;
        yeh[n] = ye;
        ceh[n] = ce;
        if (n > 0 && bh[n-1] && !byp) kstart = n;
        n++;
    endtask

    task automatic step(input int x, input bit ls, input bit byp);
        check_out();
        drive(x, ls, byp);
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        n_chk++;
        if (y_out != 0) fail_line(tag, y_out, 0);
        n_chk++;
        if (c_out != 0) fail_line(tag, c_out, 0);
        n_chk++;
        if (out_valid !== 1'b0) fail_line(tag, out_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < L; i++) begin mm[i] = 0; mk[i] = 1'b0; end
        rst_n = 1'b0; line_start = 1'b0; bypass = 1'b0;
        cvbs_in = '0; y_ext = '0; c_ext = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cur_tag = 1;
        check_reset_state("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 after release");
        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            cur_tag = V_TAG[v];
            for (int ln = 0; ln < V_LINES[v]; ln++) begin
                for (int p = 0; p < V_LEN[v]; p++) begin
                    step(gen(V_KIND[v], V_AMP[v], ln, p, n), p == 0, V_BYP[v] != 0);
                end
            end
        end
        // Flush the pipeline in comb mode
        cur_tag = 6;
        for (int i = 0; i < 8; i++) step(10, 1'b0, 1'b0);
        // Directed: reset in mid-stream clears the outputs (R1)
        cur_tag = 1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 mid-run reset");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule